// File: doc/BRIEF.md
# PLL Divider Reprogramming Sequencer

This block changes the divider settings of an integer-mode PLL without letting its output glitch. A requester presents a feedback divider, a reference divider and two post dividers and pulses a start strobe. The sequencer first decides whether the requested setting keeps the oscillator and the divided output inside their legal windows. If the setting is legal, it works through the PLL's four 32-bit control words. It moves the output onto the slow bypass clock, selects integer mode and loads the dividers. It then polls the lock flag and finally returns the output to normal mode.

Each write is a read-modify-write through one shared address port, and the read data returns in the same cycle. Only the field being programmed changes. A programmable limit bounds the lock wait. If lock does not arrive within that limit, the sequencer gives up, leaves the PLL parked in slow mode and reports an error. A rejected setting touches no register. A single-cycle done pulse, qualified by an error flag, ends every request.

Top module: `pll_reprog_seq`

## Requirements
- R1: A request is accepted only if every divider is nonzero, 16 <= fbdiv <= 3200, and with F = 24*fbdiv (MHz) both 800*refdiv <= F <= 3200*refdiv and 16*refdiv*pd1*pd2 <= F <= 3200*refdiv*pd1*pd2 hold. Any other request is rejected.
- R2: A rejected request causes no register write. `done_o` and `err_o` are both high in the second cycle after the cycle in which `start_i` was sampled high.
- R3: For an accepted request, the first write happens in the second cycle after start. It targets word 3 and sets the mode field [9:8] to slow (00), keeping all other bits of the word read back.
- R4: The second write targets word 3 and sets bit 3 to 1 (integer mode), keeping all other bits.
- R5: The third write targets word 0 and places fbdiv in bits [11:0], keeping bits [31:12].
- R6: The fourth write targets word 1 and places pd2 in [14:12], pd1 in [10:8] and refdiv in [5:0], keeping all other bits.
- R7: After the divider write, the block reads word 2 every cycle until bit 31 reads 1. In the next cycle it writes mode field [9:8] = normal (01) in word 3, keeping other bits. `done_o` with `err_o` low follows one cycle after that.
- R8: With a nonzero lock limit N, if bit 31 has not read 1 in any of the first N wait cycles, the wait ends. No normal-mode write occurs, and `done_o` with `err_o` high appears N+1 cycles after the divider write. A limit of 0 waits without bound. Lock seen in wait cycle N still wins.
- R9: `start_i` and the parameter inputs are ignored while a request is in progress. Only the values captured at start are written.
- R10: After reset `done_o`, `err_o` and `reg_we_o` are low. `done_o` is high for exactly one cycle per request, and `err_o` is never high without `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled while idle |
| fbdiv_i | input | 12 | Requested feedback divider |
| refdiv_i | input | 6 | Requested reference divider |
| pd1_i | input | 3 | Requested first post divider |
| pd2_i | input | 3 | Requested second post divider |
| lock_limit_i | input | 16 | Lock wait limit in cycles, 0 = unbounded |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request rejected or lock timed out, valid with done |
| reg_addr_o | output | 2 | Control word index for read and write |
| reg_rd_i | input | 32 | Read data of the addressed word, same cycle |
| reg_we_o | output | 1 | Write strobe |
| reg_wd_o | output | 32 | Merged write data |

## Verification
Directed cases sit on each edge of the legality window. These include oscillator exactly at its lower and upper limits and one step beyond each, feedback divider 3200 against 3201 at a legal oscillator, and zero reference or post dividers. Together they separate a correct rule from an off-by-one or a missing term. Lock delays of N-1 and N against a limit of N, a missing lock, and a zero limit with a long delay pin down which of lock and abort wins and when the wait ends. Random register contents are preloaded before every request, so any write that disturbs a bit outside its field shows up in the exact write data. A second start pulse during a long wait checks that captured parameters are not overwritten.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 2;
  localparam int FB_W   = 12;
  localparam int RD_W   = 6;
  localparam int PD_W   = 3;

  localparam logic [ADDR_W-1:0] IDX_FB   = 2'd0;
  localparam logic [ADDR_W-1:0] IDX_DIV  = 2'd1;
  localparam logic [ADDR_W-1:0] IDX_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] IDX_CTL  = 2'd3;

  localparam int MODE_LSB = 8;
  localparam int MODE_W   = 2;
  localparam int DSM_BIT  = 3;
  localparam int LOCK_BIT = 31;
  localparam int PD2_LSB  = 12;
  localparam int PD1_LSB  = 8;
  localparam int RD_LSB   = 0;
  localparam int FB_LSB   = 0;

  localparam logic [MODE_W-1:0] MODE_SLOW   = 2'd0;
  localparam logic [MODE_W-1:0] MODE_NORMAL = 2'd1;

  localparam int VCO_MIN_MHZ = 800;
  localparam int VCO_MAX_MHZ = 3200;
  localparam int OUT_MIN_MHZ = 16;
  localparam int OUT_MAX_MHZ = 3200;
  localparam int FB_MIN      = 16;
  localparam int FB_MAX      = 3200;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_PARK, ST_INTMODE, ST_FBWR,
    ST_DIVWR, ST_LOCKWAIT, ST_RUN, ST_ACK, ST_NACK
  } seq_state_e;

  function automatic logic [WORD_W-1:0] field_mask(input int lsb, input int width);
    return ((WORD_W'(1) << width) - WORD_W'(1)) << lsb;
  endfunction
endpackage

// File: rtl/pll_seq_range.sv
module pll_seq_range
  import pll_seq_pkg::*;
#(
  parameter int REF_MHZ = 24
) (
  input  logic [FB_W-1:0] fb_i,
  input  logic [RD_W-1:0] rd_i,
  input  logic [PD_W-1:0] pd1_i,
  input  logic [PD_W-1:0] pd2_i,
  output logic            ok_o
);
  logic [31:0] f_mhz, post_prod, all_prod;
  logic        nz_ok, fb_ok, vco_ok, out_ok;

  always_comb begin
    f_mhz     = 32'(REF_MHZ) * 32'(fb_i);
    post_prod = 32'(pd1_i) * 32'(pd2_i);
    all_prod  = 32'(rd_i) * post_prod;
    nz_ok     = (rd_i != '0) && (pd1_i != '0) && (pd2_i != '0);
    fb_ok     = (32'(fb_i) >= 32'(FB_MIN)) && (32'(fb_i) <= 32'(FB_MAX));
    vco_ok    = (f_mhz >= 32'(VCO_MIN_MHZ) * 32'(rd_i)) &&
                (f_mhz <= 32'(VCO_MAX_MHZ) * 32'(rd_i));
    out_ok    = (f_mhz >= 32'(OUT_MIN_MHZ) * all_prod) &&
                (f_mhz <= 32'(OUT_MAX_MHZ) * all_prod);
    ok_o      = nz_ok && fb_ok && vco_ok && out_ok;
  end
endmodule

// File: rtl/pll_seq_merge.sv
module pll_seq_merge
  import pll_seq_pkg::*;
(
  input  logic [WORD_W-1:0] old_i,
  input  logic [WORD_W-1:0] mask_i,
  input  logic [WORD_W-1:0] val_i,
  output logic [WORD_W-1:0] new_o
);
  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    assign new_o[b] = mask_i[b] ? val_i[b] : old_i[b];
  end
endmodule

// File: rtl/pll_seq_lock_timer.sv
module pll_seq_lock_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en    = clr_i | run_i;
    cnt_d     = clr_i ? '0 : cnt_q + 1'b1;
    expired_o = run_i && (limit_i != '0) && (cnt_q == limit_i - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_TMO_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && limit_i != '0) |-> (cnt_q < limit_i)); // R8
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int REF_MHZ = 24,
  parameter int TMO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [FB_W-1:0]   fbdiv_i,
  input  logic [RD_W-1:0]   refdiv_i,
  input  logic [PD_W-1:0]   pd1_i,
  input  logic [PD_W-1:0]   pd2_i,
  input  logic [TMO_W-1:0]  lock_limit_i,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  input  logic [WORD_W-1:0] reg_rd_i,
  output logic              reg_we_o,
  output logic [WORD_W-1:0] reg_wd_o
);
  localparam logic [WORD_W-1:0] MODE_MASK = field_mask(MODE_LSB, MODE_W);
  localparam logic [WORD_W-1:0] DSM_MASK  = field_mask(DSM_BIT, 1);
  localparam logic [WORD_W-1:0] FB_MASK   = field_mask(FB_LSB, FB_W);
  localparam logic [WORD_W-1:0] DIV_MASK  = field_mask(PD2_LSB, PD_W) |
                                            field_mask(PD1_LSB, PD_W) |
                                            field_mask(RD_LSB, RD_W);

  seq_state_e       state_q, state_d;
  logic [FB_W-1:0]  fb_q;
  logic [RD_W-1:0]  rd_q;
  logic [PD_W-1:0]  pd1_q, pd2_q;
  logic [TMO_W-1:0] lim_q;
  logic             cap_en, rng_ok, lock_seen, tmo_exp, tmr_clr, tmr_run;
  logic [WORD_W-1:0] wr_mask, wr_val;

  pll_seq_range #(.REF_MHZ(REF_MHZ)) u_range (
    .fb_i(fb_q), .rd_i(rd_q), .pd1_i(pd1_q), .pd2_i(pd2_q), .ok_o(rng_ok)
  );

  pll_seq_lock_timer #(.CNT_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .run_i(tmr_run),
    .limit_i(lim_q), .expired_o(tmo_exp)
  );

  pll_seq_merge u_merge (
    .old_i(reg_rd_i), .mask_i(wr_mask), .val_i(wr_val), .new_o(reg_wd_o)
  );

  // Next-state logic
  always_comb begin
    cap_en    = (state_q == ST_IDLE) && start_i;
    lock_seen = reg_rd_i[LOCK_BIT];
    tmr_clr   = (state_q == ST_DIVWR);
    tmr_run   = (state_q == ST_LOCKWAIT) && !lock_seen;
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_CHECK;
      ST_CHECK:    state_d = rng_ok ? ST_PARK : ST_NACK;
      ST_PARK:     state_d = ST_INTMODE;
      ST_INTMODE:  state_d = ST_FBWR;
      ST_FBWR:     state_d = ST_DIVWR;
      ST_DIVWR:    state_d = ST_LOCKWAIT;
      ST_LOCKWAIT: begin
        if (lock_seen)    state_d = ST_RUN;
        else if (tmo_exp) state_d = ST_NACK;
      end
      ST_RUN:      state_d = ST_ACK;
      ST_ACK:      state_d = ST_IDLE;
      ST_NACK:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  // Register-port drive
  always_comb begin
    reg_addr_o = IDX_FB;
    reg_we_o   = 1'b0;
    wr_mask    = '0;
    wr_val     = '0;
    unique case (state_q)
      ST_PARK: begin
        reg_addr_o = IDX_CTL; reg_we_o = 1'b1;
        wr_mask = MODE_MASK;  wr_val = WORD_W'(MODE_SLOW) << MODE_LSB;
      end
      ST_INTMODE: begin
        reg_addr_o = IDX_CTL; reg_we_o = 1'b1;
        wr_mask = DSM_MASK;   wr_val = DSM_MASK;
      end
      ST_FBWR: begin
        reg_addr_o = IDX_FB;  reg_we_o = 1'b1;
        wr_mask = FB_MASK;    wr_val = WORD_W'(fb_q) << FB_LSB;
      end
      ST_DIVWR: begin
        reg_addr_o = IDX_DIV; reg_we_o = 1'b1;
        wr_mask = DIV_MASK;
        wr_val  = (WORD_W'(pd2_q) << PD2_LSB) | (WORD_W'(pd1_q) << PD1_LSB) |
                  (WORD_W'(rd_q) << RD_LSB);
      end
      ST_LOCKWAIT: reg_addr_o = IDX_STAT;
      ST_RUN: begin
        reg_addr_o = IDX_CTL; reg_we_o = 1'b1;
        wr_mask = MODE_MASK;  wr_val = WORD_W'(MODE_NORMAL) << MODE_LSB;
      end
      default: ;
    endcase
    done_o = (state_q == ST_ACK) || (state_q == ST_NACK);
    err_o  = (state_q == ST_NACK);
  end

  // State and capture registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q <= '0; rd_q <= '0; pd1_q <= '0; pd2_q <= '0; lim_q <= '0;
    end else if (cap_en) begin
      fb_q <= fbdiv_i; rd_q <= refdiv_i; pd1_q <= pd1_i; pd2_q <= pd2_i;
      lim_q <= lock_limit_i;
    end
  end

  AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && !rng_ok) |=> (!reg_we_o && done_o && err_o)); // R2
  AST_FB_AFTER_INTMODE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o && reg_addr_o == IDX_FB) |->
      $past(reg_we_o && reg_addr_o == IDX_CTL && reg_wd_o[DSM_BIT])); // R4
  AST_DIV_AFTER_FB: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o && reg_addr_o == IDX_DIV) |-> $past(reg_we_o && reg_addr_o == IDX_FB)); // R5
  AST_NORMAL_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_o && reg_addr_o == IDX_CTL && reg_wd_o[MODE_LSB +: MODE_W] == MODE_NORMAL) |->
      $past(reg_addr_o == IDX_STAT && reg_rd_i[LOCK_BIT])); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
endmodule

// File: tb/pll_reprog_seq_bench.sv
module pll_reprog_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [11:0] fbdiv_i;
  logic [5:0]  refdiv_i;
  logic [2:0]  pd1_i, pd2_i;
  logic [15:0] lock_limit_i;
  logic        done_o, err_o, reg_we_o;
  logic [1:0]  reg_addr_o;
  logic [31:0] reg_rd_i, reg_wd_o;

  pll_reprog_seq u_pll_reprog_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fbdiv_i(fbdiv_i),
    .refdiv_i(refdiv_i), .pd1_i(pd1_i), .pd2_i(pd2_i),
    .lock_limit_i(lock_limit_i), .done_o(done_o), .err_o(err_o),
    .reg_addr_o(reg_addr_o), .reg_rd_i(reg_rd_i), .reg_we_o(reg_we_o),
    .reg_wd_o(reg_wd_o)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Register bank and lock model
  logic [31:0] bank [4];
  logic [31:0] init_v [4];
  logic        load_req = 1'b0, lk_never = 1'b0, lk_armed = 1'b0;
  int          lk_delay = 0, lk_cnt = 0;

  always @(posedge clk) begin
    if (load_req) begin
      for (int i = 0; i < 4; i++) bank[i] <= init_v[i];
      lk_armed <= 1'b0; lk_cnt <= 0;
    end else if (reg_we_o) begin
      bank[reg_addr_o] <= reg_wd_o;
      if (reg_addr_o == 2'd1) begin lk_armed <= 1'b1; lk_cnt <= lk_delay; end
    end else if (lk_cnt != 0) lk_cnt <= lk_cnt - 1;
  end

  assign reg_rd_i = (reg_addr_o == 2'd2) ?
                    {lk_armed && !lk_never && lk_cnt == 0, bank[2][30:0]} : bank[reg_addr_o];

  // Monitor, sampling at the falling edge
  logic        log_clr = 1'b0, seen_done, done_e;
  int          n_wr, n_done, done_c;
  logic [1:0]  log_a [8];
  logic [31:0] log_d [8];
  int          log_c [8];

  always @(negedge clk) begin
    if (log_clr) begin
      n_wr = 0; n_done = 0; seen_done = 1'b0;
    end else begin
      if (reg_we_o) begin
        if (n_wr < 8) begin log_a[n_wr] = reg_addr_o; log_d[n_wr] = reg_wd_o; log_c[n_wr] = cyc; end
        n_wr++;
      end
      if (done_o) begin
        n_done++;
        if (!seen_done) begin seen_done = 1'b1; done_c = cyc; done_e = err_o; end
      end
    end
  end

  task automatic chk(input bit cond, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit legal(input int fb, input int rd, input int p1, input int p2);
    longint f = 24 * fb;
    if (rd == 0 || p1 == 0 || p2 == 0) return 1'b0;
    if (fb < 16 || fb > 3200) return 1'b0;
    if (f < 800 * rd || f > 3200 * rd) return 1'b0;
    if (f < 16 * rd * p1 * p2 || f > 3200 * rd * p1 * p2) return 1'b0;
    return 1'b1;
  endfunction

  task automatic run_case(input int fb, input int rd, input int p1, input int p2,
                          input int d, input bit never, input int tmo, input bit mid);
    logic [31:0] i0, i1, i2, i3, e0, e1, e2, e3, e4;
    int s;
    bit ok, succ;
    i0 = $urandom(); i1 = $urandom(); i2 = $urandom(); i3 = $urandom();
    ok   = legal(fb, rd, p1, p2);
    succ = !never && (tmo == 0 || d < tmo);
    e0 = i3 & ~32'h300;
    e1 = e0 | 32'h8;
    e2 = (i0 & ~32'hfff) | 32'(fb);
    e3 = (i1 & ~32'h773f) | (32'(p2) << 12) | (32'(p1) << 8) | 32'(rd);
    e4 = (e1 & ~32'h300) | 32'h100;
    @(posedge clk); #2;
    init_v[0] = i0; init_v[1] = i1; init_v[2] = i2; init_v[3] = i3;
    load_req = 1'b1; log_clr = 1'b1; lk_delay = d; lk_never = never;
    @(posedge clk); #2;
    load_req = 1'b0; log_clr = 1'b0;
    fbdiv_i = 12'(fb); refdiv_i = 6'(rd); pd1_i = 3'(p1); pd2_i = 3'(p2);
    lock_limit_i = 16'(tmo); start_i = 1'b1; s = cyc;
    @(posedge clk); #2;
    start_i = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (seen_done) break;
      if (mid && k == 8) begin
        start_i = 1'b1; fbdiv_i = 12'(fb + 3); refdiv_i = 6'(rd + 1); lock_limit_i = 16'd1;
      end else if (mid && k == 9) begin
        start_i = 1'b0;
      end
      @(posedge clk); #2;
    end
    chk(seen_done, "R7", "request completes", seen_done, 1);
    chk((n_wr > 0) == ok, "R1", "legality decision", n_wr, ok ? 5 : 0);
    if (!ok) begin
      chk(n_wr == 0, "R2", "no write on reject", n_wr, 0);
      chk(done_c == s + 2, "R2", "reject done cycle", done_c, s + 2);
      chk(done_e == 1'b1, "R2", "reject error", done_e, 1);
      chk(bank[3] == i3 && bank[1] == i1, "R2", "words untouched", bank[3], i3);
    end else begin
      chk(log_c[0] == s + 2, "R3", "first write cycle", log_c[0], s + 2);
      chk(log_a[0] == 2'd3 && log_d[0] == e0, "R3", "slow mode write", log_d[0], e0);
      chk(log_a[1] == 2'd3 && log_d[1] == e1, "R4", "integer mode write", log_d[1], e1);
      chk(log_a[2] == 2'd0 && log_d[2] == e2, "R5", "feedback write", log_d[2], e2);
      chk(log_a[3] == 2'd1 && log_d[3] == e3, "R6", "divider write", log_d[3], e3);
      if (succ) begin
        chk(n_wr == 5, "R7", "write count", n_wr, 5);
        chk(log_a[4] == 2'd3 && log_d[4] == e4, "R7", "normal mode write", log_d[4], e4);
        chk(done_e == 1'b0, "R7", "no error", done_e, 0);
        chk(done_c == log_c[3] + d + 3, "R7", "done after lock", done_c, log_c[3] + d + 3);
      end else begin
        chk(n_wr == 4, "R8", "no normal write", n_wr, 4);
        chk(done_e == 1'b1, "R8", "timeout error", done_e, 1);
        chk(done_c == log_c[3] + tmo + 1, "R8", "abort cycle", done_c, log_c[3] + tmo + 1);
        chk(bank[3] == e1, "R8", "left in slow mode", bank[3], e1);
      end
    end
    repeat (3) @(posedge clk);
    #2;
    chk(n_done == 1, "R10", "single done pulse", n_done, 1);
    chk(!err_o && !done_o, "R10", "quiet after done", {done_o, err_o}, 0);
    if (mid) begin
      chk(n_wr == 5, "R9", "no restart", n_wr, 5);
      chk(bank[0][11:0] == 12'(fb), "R9", "captured fbdiv kept", bank[0][11:0], fb);
    end
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; fbdiv_i = '0; refdiv_i = '0;
    pd1_i = '0; pd2_i = '0; lock_limit_i = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    chk(!done_o && !err_o && !reg_we_o, "R10", "reset outputs", {done_o, err_o, reg_we_o}, 0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk(!done_o && !err_o && !reg_we_o, "R10", "idle outputs", {done_o, err_o, reg_we_o}, 0);
    // directed legality edges (R1)
    run_case(100, 1, 3, 1, 2, 1'b0, 10, 1'b0);
    run_case(100, 3, 7, 7, 0, 1'b0, 10, 1'b0);
    run_case(33, 1, 1, 1, 0, 1'b0, 10, 1'b0);
    run_case(400, 3, 1, 1, 1, 1'b0, 10, 1'b0);
    run_case(401, 3, 1, 1, 1, 1'b0, 10, 1'b0);
    run_case(3200, 63, 1, 1, 3, 1'b0, 10, 1'b0);
    run_case(3201, 63, 1, 1, 3, 1'b0, 10, 1'b0);
    run_case(100, 0, 1, 1, 0, 1'b0, 10, 1'b0);
    run_case(100, 1, 0, 1, 0, 1'b0, 10, 1'b0);
    run_case(100, 1, 2, 0, 0, 1'b0, 10, 1'b0);
    // lock wait edges (R7, R8)
    run_case(100, 1, 2, 1, 4, 1'b0, 5, 1'b0);
    run_case(100, 1, 2, 1, 5, 1'b0, 5, 1'b0);
    run_case(100, 1, 2, 1, 0, 1'b1, 3, 1'b0);
    run_case(100, 1, 2, 1, 40, 1'b0, 0, 1'b0);
    // restart attempt while busy (R9)
    run_case(120, 2, 1, 1, 30, 1'b0, 0, 1'b1);
    // random mix
    for (int n = 0; n < 60; n++) begin
      int rd, fb, p1, p2;
      if (n % 2 == 0) begin
        rd = $urandom_range(1, 4); fb = $urandom_range(30 * rd, 140 * rd);
        p1 = $urandom_range(1, 7); p2 = $urandom_range(1, 7);
      end else begin
        rd = $urandom_range(0, 63); fb = $urandom_range(0, 4095);
        p1 = $urandom_range(0, 7); p2 = $urandom_range(0, 7);
      end
      run_case(fb, rd, p1, p2, $urandom_range(0, 12), 1'b0,
               ($urandom_range(0, 1) == 1) ? 10 : 0, 1'b0);
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog: actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule